// File: doc/BRIEF.md
# Simulation Test-Status Control Peripheral

A small write-only register block for simulation environments. A processor under test reports its outcome through it and ends the run with it. Software writes a pointer to a short text label. The block then becomes a bus master, reads sixteen bytes of that label from system memory into a local buffer and forces the final byte to zero, so the label is always terminated. Software then writes a result code: zero means pass, anything else means fail. The block answers with a one-cycle result strobe. A write to the control word asks the environment to shut the simulation down.

The surrounding testbench does all printing and formatting, driven by the strobes and the captured label bytes. Register read-back and bus arbitration are outside the block. A slave access is taken in the cycle it is presented. Accesses that fall inside the 16-byte window but are not legal writes to a defined word raise a one-cycle error pulse and change no state.

Top module: `sim_status_ctrl`

## Requirements
- R1: The window is the 16-byte aligned block at parameter BASE (default 0xFFFF0000). The word offset is s_addr[3:2]: 0 = shutdown control, 1 = result code, 2 = label pointer, 3 = unmapped. An access outside the window changes nothing and raises no error.
- R2: Only writes (s_write=1) with s_bytes=4 and s_addr[1:0]=0 are legal. Inside the window, a read, any other size or a misaligned address pulses err_o high for one cycle, in the cycle after the access, and changes no state.
- R3: A legal write to offset 3 pulses err_o in the cycle after the access. It raises no shutdown and no result strobe and leaves the pointer and the result code unchanged.
- R4: A legal write to offset 0, whatever its data, drives shutdown_o high for exactly the cycle after the write, with err_o low.
- R5: A legal write to offset 1 shows the value on result_value_o from the next cycle. result_o pulses for one cycle, with result_fail_o=1 when the value is non-zero and 0 when it is zero. With no label fetch in progress, the pulse comes in the cycle after the write.
- R6: A legal write to offset 2 shows the pointer on name_ptr_o from the next cycle and starts a fetch. busy_o is high from that cycle until the cycle after the last response. The fetch issues four reads at pointer+0, +4, +8 and +12, in that order, one at a time. Each request holds m_req_valid and a stable m_req_addr until m_req_ready is sampled high, and the next request follows the previous response.
- R7: Bits [8i+7:8i] of name_o hold the memory byte at pointer+i. Within each fetched word, byte j of the word is bits [8j+7:8j] (little-endian). Byte 15 (bits [127:120]) is always zero.
- R8: If a result write arrives while busy_o is high, the strobe is deferred to the cycle in which busy_o first reads low. In that cycle name_o already holds the complete label.
- R9: A pointer write during a fetch ends the fetch after its outstanding word. The fetch then restarts from the new pointer, and the final label matches the latest pointer.
- R10: An active-low synchronous reset clears the pointer, the result code, all 16 label bytes, busy_o and every pulse output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Slave access present this cycle |
| s_write | input | 1 | 1 = write, 0 = read |
| s_addr | input | 32 | Slave byte address |
| s_bytes | input | 3 | Access size in bytes |
| s_wdata | input | 32 | Slave write data |
| m_req_valid | output | 1 | Master read request valid |
| m_req_ready | input | 1 | Memory accepts the request |
| m_req_addr | output | 32 | Master read byte address |
| m_rsp_valid | input | 1 | Read data returned this cycle |
| m_rsp_data | input | 32 | Returned read word |
| shutdown_o | output | 1 | One-cycle shutdown request |
| result_o | output | 1 | One-cycle result strobe |
| result_fail_o | output | 1 | 1 when the stored result code is non-zero |
| result_value_o | output | 32 | Stored result code |
| name_ptr_o | output | 32 | Stored label pointer |
| name_o | output | 128 | Captured label bytes |
| busy_o | output | 1 | Label fetch in progress |
| err_o | output | 1 | One-cycle error on a rejected access |

## Verification
The hardest situations to reach are a pointer rewrite that lands while a read is still outstanding and a result write that lands mid-fetch. Both depend on where the master sequencer stands when the slave write arrives. A bench memory responder stalls ready and response by random amounts, so that directed writes placed a few cycles after a pointer write land in the request phase and in the response wait. The bench then checks that the result strobe appears only when the fetch ends and that the label matches the newest pointer.

// File: rtl/sim_status_pkg.sv
// Shared types for the test-status control block.
// Assumes a single clock domain; no state lives here.
package sim_status_pkg;

    // Word offsets inside the register window; the decoder compares against these.
    localparam int OFS_CTRL   = 0;
    localparam int OFS_RESULT = 1;
    localparam int OFS_PTR    = 2;

    // Master read sequencer states.
    typedef enum logic [1:0] {
        FETCH_IDLE = 2'd0,
        FETCH_REQ  = 2'd1,
        FETCH_WAIT = 2'd2
    } fetch_state_t;

    // One-hot-or-none classification of the current slave access.
    typedef struct packed {
        logic ctrl_wr;
        logic result_wr;
        logic ptr_wr;
        logic bad;
    } acc_dec_t;

endpackage

// File: rtl/sim_status_decode.sv
// Classifies one slave access against the register window.
// Assumes BASE is aligned to the window size (WIN_WORDS words of 4 bytes).
// Pure combinational; the caller registers any pulse it derives.
module sim_status_decode
    import sim_status_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter int              WIN_WORDS = 4,
    parameter logic [ADDR_W-1:0] BASE    = 32'hFFFF_0000
) (
    input  logic              s_valid,
    input  logic              s_write,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [2:0]        s_bytes,
    output acc_dec_t          dec_o
);
    localparam int WIN_LSB = $clog2(WIN_WORDS * 4);
    localparam int OW      = WIN_LSB - 2;

    logic          in_win;
    logic          legal;
    logic [OW-1:0] ofs;

    // Window hit, legality and word offset of the access.
    always_comb begin
        in_win = s_valid && (s_addr[ADDR_W-1:WIN_LSB] == BASE[ADDR_W-1:WIN_LSB]);
        legal  = s_write && (s_bytes == 3'd4) && (s_addr[1:0] == 2'b00);
        ofs    = s_addr[WIN_LSB-1:2];
    end

    // Select exactly one action, or flag an error, for an in-window access.
    always_comb begin
        dec_o = '0;
        if (in_win) begin
            if (!legal) begin
                dec_o.bad = 1'b1;
            end else if (ofs == OW'(OFS_CTRL)) begin
                dec_o.ctrl_wr = 1'b1;
            end else if (ofs == OW'(OFS_RESULT)) begin
                dec_o.result_wr = 1'b1;
            end else if (ofs == OW'(OFS_PTR)) begin
                dec_o.ptr_wr = 1'b1;
            end else begin
                dec_o.bad = 1'b1;
            end
        end
    end

    // R3/R2: an access never both acts and errors.
    always_comb begin
        assert_dec_onehot_R3: assert ($onehot0(dec_o));
    end

endmodule

// File: rtl/sim_status_fetch.sv
// Master read sequencer and label buffer.
// Reads NAME_BYTES bytes as sequential DATA_W-bit words, one request in
// flight at a time. A new start during a fetch is remembered and replayed
// from the latest pointer once the outstanding word returns. Assumes the
// pointer is word aligned and memory answers each accepted request once.
module sim_status_fetch
    import sim_status_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int NAME_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [ADDR_W-1:0]       start_addr_i,
    input  logic [ADDR_W-1:0]       ptr_i,
    output logic                    m_req_valid,
    input  logic                    m_req_ready,
    output logic [ADDR_W-1:0]       m_req_addr,
    input  logic                    m_rsp_valid,
    input  logic [DATA_W-1:0]       m_rsp_data,
    output logic [NAME_BYTES*8-1:0] name_o,
    output logic                    busy_o,
    output logic                    busy_next_o
);
    localparam int BYTES_W = DATA_W / 8;
    localparam int WORDS   = NAME_BYTES / BYTES_W;
    localparam int IDX_W   = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

    fetch_state_t      st_q, st_n;
    logic [ADDR_W-1:0] base_q, base_n;
    logic [IDX_W-1:0]  idx_q, idx_n;
    logic              restart_q, restart_n;
    logic              rsp_take;
    logic              redo;

    // Response acceptance and restart request for this cycle.
    always_comb begin
        rsp_take = (st_q == FETCH_WAIT) && m_rsp_valid;
        redo     = restart_q || start_i;
    end

    // Next-state logic of the sequencer.
    always_comb begin
        st_n      = st_q;
        base_n    = base_q;
        idx_n     = idx_q;
        restart_n = restart_q;
        case (st_q)
            FETCH_IDLE: begin
                if (start_i) begin
                    st_n      = FETCH_REQ;
                    base_n    = start_addr_i;
                    idx_n     = '0;
                    restart_n = 1'b0;
                end
            end
            FETCH_REQ: begin
                restart_n = redo;
                if (m_req_ready) begin
                    st_n = FETCH_WAIT;
                end
            end
            FETCH_WAIT: begin
                restart_n = redo;
                if (m_rsp_valid) begin
                    if (redo) begin
                        st_n      = FETCH_REQ;
                        base_n    = start_i ? start_addr_i : ptr_i;
                        idx_n     = '0;
                        restart_n = 1'b0;
                    end else if (idx_q == LAST) begin
                        st_n = FETCH_IDLE;
                    end else begin
                        st_n  = FETCH_REQ;
                        idx_n = idx_q + 1'b1;
                    end
                end
            end
            default: st_n = FETCH_IDLE;
        endcase
    end

    // Sequencer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= FETCH_IDLE;
            base_q    <= '0;
            idx_q     <= '0;
            restart_q <= 1'b0;
        end else begin
            st_q      <= st_n;
            base_q    <= base_n;
            idx_q     <= idx_n;
            restart_q <= restart_n;
        end
    end

    // Request outputs and busy flags.
    always_comb begin
        m_req_valid = (st_q == FETCH_REQ);
        m_req_addr  = base_q + (ADDR_W'(idx_q) * ADDR_W'(BYTES_W));
        busy_o      = (st_q != FETCH_IDLE);
        busy_next_o = (st_n != FETCH_IDLE);
    end

    // One buffer word per fetched word; the last word keeps its top byte zero.
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [DATA_W-1:0] word_q;
        logic              wr_en;

        // Capture enable for this word.
        always_comb wr_en = rsp_take && !redo && (idx_q == IDX_W'(w));

        if (w == WORDS - 1) begin : g_last
            // Store the final word with its terminating byte forced to zero.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else if (wr_en) begin
                    word_q <= {8'h00, m_rsp_data[DATA_W-9:0]};
                end
            end
        end else begin : g_body
            // Store a body word unchanged.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else if (wr_en) begin
                    word_q <= m_rsp_data;
                end
            end
        end

        assign name_o[w*DATA_W +: DATA_W] = word_q;
    end

    // R6: a pending request holds valid and address until accepted.
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req_valid && !m_req_ready) |=> (m_req_valid && $stable(m_req_addr)));

    // R7: the label is always terminated.
    assert_name_term_R7: assert property (@(posedge clk) disable iff (!rst_n)
        name_o[NAME_BYTES*8-1 -: 8] == 8'h00);

    // R9: a restart request never leaves the sequencer idle.
    assert_restart_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart_q |-> busy_o);

endmodule

// File: rtl/sim_status_report.sv
// Result code register and result strobe sequencing.
// Holds the strobe back while a label fetch runs, so the reported label
// always belongs to the latest pointer. Assumes busy_next_i is the value
// busy will take after this clock edge.
module sim_status_report #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              result_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              busy_i,
    input  logic              busy_next_i,
    output logic              result_o,
    output logic              result_fail_o,
    output logic [DATA_W-1:0] result_value_o
);
    logic [DATA_W-1:0] value_q;
    logic              pend_q;
    logic              strobe_q;
    logic              want;

    // A strobe is owed by a new write or an earlier deferred one.
    always_comb want = result_wr_i || pend_q;

    // Store the code; fire when the fetch is (or becomes) idle, else defer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q  <= '0;
            pend_q   <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            if (result_wr_i) begin
                value_q <= wdata_i;
            end
            strobe_q <= want && !busy_next_i;
            pend_q   <= want && busy_next_i;
        end
    end

    // Outputs.
    always_comb begin
        result_o       = strobe_q;
        result_value_o = value_q;
        result_fail_o  = (value_q != '0);
    end

    // R8: the strobe never coincides with an active fetch.
    assert_result_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        result_o |-> !busy_i);

    // R8: a deferred strobe is never outstanding while idle.
    assert_pend_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> busy_i);

endmodule

// File: rtl/sim_status_ctrl.sv
// Simulation test-status control peripheral (top).
// Write-only register window for shutdown, result code and label pointer,
// plus a read master that copies a terminated label from memory.
// Assumes one slave access per cycle, always accepted in its cycle.
module sim_status_ctrl
    import sim_status_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                DATA_W     = 32,
    parameter int                NAME_BYTES = 16,
    parameter int                WIN_WORDS  = 4,
    parameter logic [ADDR_W-1:0] BASE       = 32'hFFFF_0000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    s_valid,
    input  logic                    s_write,
    input  logic [ADDR_W-1:0]       s_addr,
    input  logic [2:0]              s_bytes,
    input  logic [DATA_W-1:0]       s_wdata,
    output logic                    m_req_valid,
    input  logic                    m_req_ready,
    output logic [ADDR_W-1:0]       m_req_addr,
    input  logic                    m_rsp_valid,
    input  logic [DATA_W-1:0]       m_rsp_data,
    output logic                    shutdown_o,
    output logic                    result_o,
    output logic                    result_fail_o,
    output logic [DATA_W-1:0]       result_value_o,
    output logic [ADDR_W-1:0]       name_ptr_o,
    output logic [NAME_BYTES*8-1:0] name_o,
    output logic                    busy_o,
    output logic                    err_o
);
    acc_dec_t          dec;
    logic              shut_q;
    logic              err_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              busy_next;
    logic [ADDR_W-1:0] start_addr;

    // Pointer as seen by the sequencer on a fresh start.
    always_comb start_addr = ADDR_W'(s_wdata);

    sim_status_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_WORDS(WIN_WORDS),
        .BASE     (BASE)
    ) u_decode (
        .s_valid(s_valid),
        .s_write(s_write),
        .s_addr (s_addr),
        .s_bytes(s_bytes),
        .dec_o  (dec)
    );

    // Shutdown and error pulses, and the pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shut_q <= 1'b0;
            err_q  <= 1'b0;
            ptr_q  <= '0;
        end else begin
            shut_q <= dec.ctrl_wr;
            err_q  <= dec.bad;
            if (dec.ptr_wr) begin
                ptr_q <= start_addr;
            end
        end
    end

    sim_status_fetch #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .NAME_BYTES(NAME_BYTES)
    ) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (dec.ptr_wr),
        .start_addr_i(start_addr),
        .ptr_i       (ptr_q),
        .m_req_valid (m_req_valid),
        .m_req_ready (m_req_ready),
        .m_req_addr  (m_req_addr),
        .m_rsp_valid (m_rsp_valid),
        .m_rsp_data  (m_rsp_data),
        .name_o      (name_o),
        .busy_o      (busy_o),
        .busy_next_o (busy_next)
    );

    sim_status_report #(
        .DATA_W(DATA_W)
    ) u_report (
        .clk           (clk),
        .rst_n         (rst_n),
        .result_wr_i   (dec.result_wr),
        .wdata_i       (s_wdata),
        .busy_i        (busy_o),
        .busy_next_i   (busy_next),
        .result_o      (result_o),
        .result_fail_o (result_fail_o),
        .result_value_o(result_value_o)
    );

    // Pulse and pointer outputs.
    always_comb begin
        shutdown_o = shut_q;
        err_o      = err_q;
        name_ptr_o = ptr_q;
    end

    // R2: a rejected access leaves the pointer and result code untouched.
    assert_bad_nochange_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($stable(name_ptr_o) && $stable(result_value_o)));

    // R4: a shutdown pulse is never an error pulse.
    assert_shutdown_noerr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_o |-> !err_o);

endmodule

// File: tb/sim_sim_status_ctrl.sv
`timescale 1ns/1ps
module sim_sim_status_ctrl;
    localparam logic [31:0] BASE = 32'hFFFF_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         s_valid = 1'b0;
    logic         s_write = 1'b0;
    logic [31:0]  s_addr = '0;
    logic [2:0]   s_bytes = 3'd0;
    logic [31:0]  s_wdata = '0;
    logic         m_req_valid;
    logic         m_req_ready = 1'b0;
    logic [31:0]  m_req_addr;
    logic         m_rsp_valid = 1'b0;
    logic [31:0]  m_rsp_data = '0;
    logic         shutdown_o, result_o, result_fail_o, busy_o, err_o;
    logic [31:0]  result_value_o, name_ptr_o;
    logic [127:0] name_o;

    int n_chk = 0;
    int n_fail = 0;
    logic sam_err, sam_shut, sam_res, sam_busy;
    logic [31:0] acc_log [16];
    int acc_n = 0;
    logic [31:0] exp_val = '0;
    logic [31:0] exp_ptr = '0;

    always #2 clk = ~clk;

    sim_status_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_valid), .s_write(s_write), .s_addr(s_addr),
        .s_bytes(s_bytes), .s_wdata(s_wdata),
        .m_req_valid(m_req_valid), .m_req_ready(m_req_ready),
        .m_req_addr(m_req_addr), .m_rsp_valid(m_rsp_valid),
        .m_rsp_data(m_rsp_data),
        .shutdown_o(shutdown_o), .result_o(result_o),
        .result_fail_o(result_fail_o), .result_value_o(result_value_o),
        .name_ptr_o(name_ptr_o), .name_o(name_o), .busy_o(busy_o),
        .err_o(err_o)
    );

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {mem_byte(a + 32'd3), mem_byte(a + 32'd2), mem_byte(a + 32'd1), mem_byte(a)};
    endfunction

    function automatic logic [127:0] exp_name(input logic [31:0] p);
        logic [127:0] r;
        r = '0;
        for (int i = 0; i < 15; i++) r[8*i +: 8] = mem_byte(p + 32'(i));
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Slave access: drive at a falling edge, sample pulses one cycle later.
    task automatic acc(input logic wr, input logic [31:0] a, input logic [2:0] nb, input logic [31:0] d);
        @(negedge clk);
        s_valid = 1'b1; s_write = wr; s_addr = a; s_bytes = nb; s_wdata = d;
        @(negedge clk);
        s_valid = 1'b0;
        sam_err = err_o; sam_shut = shutdown_o; sam_res = result_o; sam_busy = busy_o;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400; i++) begin
            if (!busy_o) break;
            @(negedge clk);
        end
    endtask

    // Memory responder with random ready and response delays.
    initial begin
        forever begin
            @(negedge clk);
            m_rsp_valid = 1'b0;
            m_req_ready = 1'b0;
            if (m_req_valid && rst_n) begin
                logic [31:0] a;
                repeat ($urandom % 3) @(negedge clk);
                a = m_req_addr;
                m_req_ready = 1'b1;
                @(negedge clk);
                m_req_ready = 1'b0;
                if (acc_n < 16) acc_log[acc_n] = a;
                acc_n++;
                repeat ($urandom % 3) @(negedge clk);
                m_rsp_valid = 1'b1;
                m_rsp_data = mem_word(a);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] p, p2, d;
        int strobes;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R10: reset state
        chk(name_o == '0 && !busy_o && !result_o && !shutdown_o && !err_o &&
            result_value_o == '0 && name_ptr_o == '0, "R10 reset state",
            {name_ptr_o, result_value_o, 64'(busy_o)}, '0);
        rst_n = 1'b1;

        // R4: control write with random data
        d = $urandom;
        acc(1'b1, BASE, 3'd4, d);
        chk(sam_shut && !sam_err, "R4 shutdown pulse", {sam_shut, sam_err}, 2'b10);
        @(negedge clk);
        chk(!shutdown_o, "R4 single cycle", shutdown_o, 0);

        // R5: pass and fail codes
        acc(1'b1, BASE + 32'd4, 3'd4, 32'd0);
        exp_val = 0;
        chk(sam_res && !result_fail_o && result_value_o == 0, "R5 pass code",
            {sam_res, result_fail_o}, 2'b10);
        d = $urandom | 32'h1;
        acc(1'b1, BASE + 32'd4, 3'd4, d);
        exp_val = d;
        chk(sam_res && result_fail_o && result_value_o == d, "R5 fail code", result_value_o, d);
        @(negedge clk);
        chk(!result_o, "R5 strobe single cycle", result_o, 0);

        // R2: read, narrow write, misaligned write
        acc(1'b0, BASE + 32'd4, 3'd4, 32'h0);
        chk(sam_err && result_value_o == exp_val, "R2 read rejected", result_value_o, exp_val);
        acc(1'b1, BASE + 32'd4, 3'd2, 32'h0);
        chk(sam_err && !sam_res && result_value_o == exp_val, "R2 narrow write", result_value_o, exp_val);
        acc(1'b1, BASE + 32'd9, 3'd4, 32'h1234);
        chk(sam_err && !sam_busy && name_ptr_o == 0, "R2 misaligned", name_ptr_o, 0);
        @(negedge clk);
        chk(!err_o, "R2 error single cycle", err_o, 0);

        // R3: unmapped offset
        acc(1'b1, BASE + 32'd12, 3'd4, 32'hDEAD_BEEF);
        chk(sam_err && !sam_shut && !sam_res && !sam_busy && name_ptr_o == 0 &&
            result_value_o == exp_val, "R3 unmapped", {sam_err, sam_shut, sam_res}, 3'b100);

        // R1: outside window ignored
        acc(1'b1, BASE + 32'd16, 3'd4, 32'h5);
        chk(!sam_err && !sam_res && !sam_shut && !sam_busy && result_value_o == exp_val,
            "R1 outside window", {sam_err, sam_shut}, 0);
        acc(1'b1, 32'h0000_0004, 3'd4, 32'h7);
        chk(!sam_err && !sam_res && result_value_o == exp_val, "R1 low address", result_value_o, exp_val);

        // R6/R7: simple fetch with address order
        p = $urandom & 32'h0FFF_FFFC;
        acc_n = 0;
        acc(1'b1, BASE + 32'd8, 3'd4, p);
        chk(sam_busy && name_ptr_o == p, "R6 pointer stored and busy", name_ptr_o, p);
        wait_idle();
        chk(acc_n == 4 && acc_log[0] == p && acc_log[1] == p + 4 && acc_log[2] == p + 8 &&
            acc_log[3] == p + 12, "R6 read order", {acc_log[0], acc_log[1], acc_log[2], acc_log[3]},
            {p, p + 32'd4, p + 32'd8, p + 32'd12});
        chk(name_o == exp_name(p), "R7 label bytes", name_o, exp_name(p));
        chk(name_o[127:120] == 8'h00, "R7 terminator", name_o[127:120], 0);

        // R8: result write during fetch is deferred
        p = $urandom & 32'h0FFF_FFFC;
        acc(1'b1, BASE + 32'd8, 3'd4, p);
        d = $urandom | 32'h1;
        acc(1'b1, BASE + 32'd4, 3'd4, d);
        chk(!sam_res && sam_busy, "R8 no strobe while busy", sam_res, 0);
        strobes = 0;
        for (int i = 0; i < 200; i++) begin
            if (result_o) begin
                strobes++;
                chk(!busy_o && name_o == exp_name(p) && result_fail_o, "R8 strobe at fetch end",
                    name_o, exp_name(p));
            end
            if (!busy_o && i > 0) break;
            @(negedge clk);
        end
        @(negedge clk);
        chk(strobes == 1 && !result_o, "R8 exactly one strobe", strobes, 1);

        // R9: pointer rewrite during fetch, at several offsets
        for (int k = 0; k < 6; k++) begin
            p = $urandom & 32'h0FFF_FFFC;
            p2 = $urandom & 32'h0FFF_FFFC;
            acc(1'b1, BASE + 32'd8, 3'd4, p);
            repeat (k) @(negedge clk);
            acc(1'b1, BASE + 32'd8, 3'd4, p2);
            wait_idle();
            chk(name_o == exp_name(p2) && name_ptr_o == p2, "R9 label follows newest pointer",
                name_o, exp_name(p2));
        end

        // Random mix against the model.
        for (int it = 0; it < 60; it++) begin
            int op;
            op = $urandom % 5;
            d = $urandom;
            case (op)
                0: begin
                    acc(1'b1, BASE, 3'd4, d);
                    chk(sam_shut && !sam_err, "R4 random shutdown", sam_shut, 1);
                end
                1: begin
                    acc(1'b1, BASE + 32'd4, 3'd4, d);
                    exp_val = d;
                    chk(sam_res && result_value_o == d && result_fail_o == (d != 0),
                        "R5 random result", result_value_o, d);
                end
                2: begin
                    p = d & 32'h0FFF_FFFC;
                    acc(1'b1, BASE + 32'd8, 3'd4, p);
                    exp_ptr = p;
                    wait_idle();
                    chk(name_o == exp_name(p), "R7 random label", name_o, exp_name(p));
                end
                3: begin
                    acc(1'b1, BASE + {28'h0, d[3:2], 2'b00}, 3'(1 + (d[5:4])), d);
                    if (d[5:4] == 2'd3) begin
                        // legal size: drain any effect and resync the model
                        wait_idle();
                        if (d[3:2] == 2'd1) exp_val = d;
                        if (d[3:2] == 2'd2) exp_ptr = d;
                    end else begin
                        chk(sam_err && result_value_o == exp_val, "R2 random narrow", result_value_o, exp_val);
                    end
                end
                default: begin
                    acc(1'b1, BASE + 32'd12, 3'd4, d);
                    chk(sam_err && !sam_shut && result_value_o == exp_val, "R3 random unmapped",
                        result_value_o, exp_val);
                end
            endcase
        end

        // R10: reset during a fetch
        p = $urandom & 32'h0FFF_FFFC;
        acc(1'b1, BASE + 32'd8, 3'd4, p);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy_o && name_o == '0 && name_ptr_o == '0 && result_value_o == '0 && !m_req_valid,
            "R10 reset mid fetch", {name_ptr_o, result_value_o}, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule